// File: doc/BRIEF.md
# Current-Input ADC Frame Readout Controller

This block sits on the host side of a serial link to a 32-channel current-input converter. When the converter signals that a conversion result is ready (an active-low ready line falls), the controller generates a gated serial data clock from the system clock. It shifts in every channel word of the frame and hands each word out as a parallel value. Each word comes with a channel index, an offset-corrected signed copy and a one-cycle strobe.

The controller also owns the converter's integrator-swap line. A single-cycle request toggles that line, but never while serial clocking is in progress. Before the toggle the data clock must already have been quiet for a programmable number of system clocks, and it stays quiet for the same number of clocks afterwards. Requests that arrive mid-frame wait for the frame to end. Ready edges that arrive inside a guard window are remembered and served once the window closes.

Top module: `curadc_readout`

## Requirements
- R1: A frame starts only after a falling edge of `drdy_n_i`. The line is resynchronised through two flops before edge detection. Rising edges, including the one the converter makes after the first data-clock falling edge, start nothing, and `dclk_o` stays low while no frame runs.
- R2: While a frame runs, `dclk_o` starts low and toggles every `DIV_HALF` system clocks. `sdata_i` is sampled on the system clock edge at which `dclk_o` goes high, and `dclk_o` ends the frame low.
- R3: A frame has exactly NCH×W rising `dclk_o` edges. W is 20 when `fmt20_i`=1 and 16 when `fmt20_i`=0, taken from `fmt20_i` as latched when the frame starts. Later changes of `fmt20_i` do not affect the running frame.
- R4: Words are received MSB first. The first word of a frame carries `chan_o`=NCH-1 (channel 32), and each further word carries an index one lower, down to 0 (channel 1).
- R5: In 20-bit mode `word_o` holds the 20 received bits. In 16-bit mode `word_o[15:0]` holds the 16 received bits and `word_o[19:16]` is zero.
- R6: `word_valid_o` is high for exactly one system clock per received word, 32 times per frame, with `word_o`, `chan_o` and `word_signed_o` valid in that cycle.
- R7: `word_signed_o` equals `word_o` minus the zero-input code of the frame's format: 4096 (0x01000) in 20-bit mode and 256 (0x0100) in 16-bit mode.
- R8: A falling edge of `drdy_n_i` during a running frame sets `overrun_o`, which stays 1 until reset. The running frame continues unchanged and no extra frame follows.
- R9: `conv_o` changes only after `dclk_o` has been idle for at least `GUARD_CYC` system clocks. `dclk_o` makes no edge within `GUARD_CYC` system clocks after a `conv_o` change. Each `conv_req_i` pulse toggles `conv_o` once.
- R10: A `conv_req_i` pulse during a frame leaves `conv_o` unchanged until that frame ends, then takes effect. A ready falling edge inside a guard window is held and read completely once the window closes.
- R11: After reset, `dclk_o`, `conv_o`, `word_valid_o` and `overrun_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt20_i | input | 1 | Word length select: 1 = 20 bits, 0 = 16 bits |
| conv_req_i | input | 1 | One-cycle request to toggle the integrator-swap line |
| drdy_n_i | input | 1 | Converter data-ready, active low (asynchronous) |
| sdata_i | input | 1 | Serial data from the converter |
| dclk_o | output | 1 | Gated serial data clock |
| conv_o | output | 1 | Integrator-swap line to the converter |
| word_o | output | WMAX | Received channel word, zero-extended in 16-bit mode |
| chan_o | output | $clog2(NCH) | Channel index, channel number minus one |
| word_valid_o | output | 1 | One-cycle strobe for each word |
| word_signed_o | output | WMAX+1 | Word minus the zero-input code of the format |
| overrun_o | output | 1 | Sticky: ready edge seen during a running frame |

## Verification
Frames are driven with random channel words mixed with all-zero, all-one and exact zero-code words. This separates correct bit order and channel order from shifted or reversed assembly, and the zero code pins the offset subtraction. Frames in both formats, and frames where the format input flips mid-frame, separate the latched word length from a live one. A ready pulse injected mid-frame separates overrun handling from a restart. Swap requests placed inside a frame and just ahead of a ready edge tell deferral apart from a toggle that cuts into serial clocking.

// File: rtl/curadc_rdo_pkg.sv
// Shared types and helpers for the current-ADC readout controller.
// Assumes: word widths of at least 9 bits, so the zero code is a power of two.
package curadc_rdo_pkg;

    // States of the integrator-swap guard sequencer
    typedef enum logic [1:0] {
        GRD_IDLE = 2'd0,
        GRD_PRE  = 2'd1,
        GRD_POST = 2'd2
    } grd_state_e;

    // Zero-input code of an offset-binary word of the given width
    function automatic int unsigned zero_code(input int unsigned wbits);
        return 32'd1 << (wbits - 8);
    endfunction

endpackage

// File: rtl/curadc_rdo_sclk.sv
// Serial data clock generator.
// While run_i is high, dclk_o toggles every DIV_HALF system clocks, starting
// low. rise_o and fall_o flag the system cycle whose edge makes dclk_o go high
// or low. Assumes: run_i is dropped by its owner in the cycle of the final fall.
module curadc_rdo_sclk #(
    parameter int DIV_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic dclk_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

    logic [CW-1:0] cnt_q;
    logic          dclk_q;
    logic          tick;

    assign tick   = run_i && (cnt_q == CW'(DIV_HALF - 1));
    assign rise_o = tick && !dclk_q;
    assign fall_o = tick &&  dclk_q;
    assign dclk_o = dclk_q;

    // Half-period counter and clock flop, parked low when idle
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q  <= '0;
            dclk_q <= 1'b0;
        end else if (tick) begin
            cnt_q  <= '0;
            dclk_q <= !dclk_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // R2
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !dclk_q);

endmodule

// File: rtl/curadc_rdo_frame.sv
// Frame receiver: after start_i it latches the format, shifts one bit per
// data-clock rise (MSB first) and emits NCH words, highest channel first.
// The frame ends on the data-clock fall after the last bit.
// Assumes: rise_i/fall_i come from curadc_rdo_sclk driven by run_o.
module curadc_rdo_frame #(
    parameter int NCH    = 32,
    parameter int WMAX   = 20,
    parameter int WSHORT = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic                      fmt20_i,
    input  logic                      sdata_i,
    input  logic                      rise_i,
    input  logic                      fall_i,
    output logic                      run_o,
    output logic [WMAX-1:0]           word_o,
    output logic [$clog2(NCH)-1:0]    chan_o,
    output logic                      valid_o,
    output logic signed [WMAX:0]      sval_o
);
    import curadc_rdo_pkg::*;

    localparam int CHW = $clog2(NCH);
    localparam int BW  = $clog2(WMAX);
    localparam logic signed [WMAX:0] OFS_L = (WMAX+1)'(zero_code(WMAX));
    localparam logic signed [WMAX:0] OFS_S = (WMAX+1)'(zero_code(WSHORT));

    logic                   run_q, fmt_q, last_q, valid_q;
    logic [BW-1:0]          bit_q, wtop;
    logic [CHW-1:0]         ch_q, chan_q;
    logic [WMAX-1:0]        sh_q, full, word_n, word_q;
    logic signed [WMAX:0]   ofs_v, sval_q;
    logic                   word_end;

    assign wtop     = fmt_q ? BW'(WMAX - 1) : BW'(WSHORT - 1);
    assign full     = {sh_q[WMAX-2:0], sdata_i};
    assign word_n   = fmt_q ? full : {{(WMAX-WSHORT){1'b0}}, full[WSHORT-1:0]};
    assign word_end = run_q && rise_i && (bit_q == wtop);
    assign ofs_v    = fmt_q ? OFS_L : OFS_S;

    // Frame activity flag and format latched at frame start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            fmt_q <= 1'b1;
        end else if (start_i && !run_q) begin
            run_q <= 1'b1;
            fmt_q <= fmt20_i;
        end else if (run_q && fall_i && last_q) begin
            run_q <= 1'b0;
        end
    end

    // Bit and channel counters and the input shift register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q  <= '0;
            ch_q   <= CHW'(NCH - 1);
            last_q <= 1'b0;
            sh_q   <= '0;
        end else if (start_i && !run_q) begin
            bit_q  <= '0;
            ch_q   <= CHW'(NCH - 1);
            last_q <= 1'b0;
            sh_q   <= '0;
        end else if (run_q && rise_i) begin
            sh_q <= full;
            if (bit_q == wtop) begin
                bit_q <= '0;
                if (ch_q == '0) last_q <= 1'b1;
                else            ch_q   <= ch_q - 1'b1;
            end else begin
                bit_q <= bit_q + 1'b1;
            end
        end
    end

    // Registered word output with index, signed copy and strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            word_q  <= '0;
            chan_q  <= '0;
            sval_q  <= '0;
        end else begin
            valid_q <= word_end;
            if (word_end) begin
                word_q <= word_n;
                chan_q <= ch_q;
                sval_q <= $signed({1'b0, word_n}) - ofs_v;
            end
        end
    end

    assign run_o   = run_q;
    assign word_o  = word_q;
    assign chan_o  = chan_q;
    assign valid_o = valid_q;
    assign sval_o  = sval_q;

    // R3
    bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (bit_q <= wtop));
    // R6
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);
    // R4
    first_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_q) |-> (ch_q == CHW'(NCH - 1)));

endmodule

// File: rtl/curadc_rdo_guard.sv
// Integrator-swap sequencer. A request pulse is held until allow_i (no frame
// running or pending); then the data clock is kept quiet for GUARD_CYC cycles,
// conv_o toggles, and another GUARD_CYC quiet cycles follow. busy_o marks
// both windows. Assumes: the owner starts no frame while busy_o is high.
module curadc_rdo_guard #(
    parameter int GUARD_CYC = 1250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic allow_i,
    output logic conv_o,
    output logic busy_o
);
    import curadc_rdo_pkg::*;

    localparam int GW = $clog2(GUARD_CYC + 1);

    grd_state_e    st_q;
    logic [GW-1:0] cnt_q;
    logic          pend_q, conv_q, go, win_end;

    assign go      = (st_q == GRD_IDLE) && pend_q && allow_i;
    assign win_end = (cnt_q == GW'(GUARD_CYC - 1));

    // Remember a swap request until the sequence is launched
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= req_i || (pend_q && !go);
    end

    // Pre-guard, toggle, post-guard sequence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= GRD_IDLE;
            cnt_q  <= '0;
            conv_q <= 1'b0;
        end else begin
            case (st_q)
                GRD_IDLE: if (go) begin
                    st_q  <= GRD_PRE;
                    cnt_q <= '0;
                end
                GRD_PRE: if (win_end) begin
                    st_q   <= GRD_POST;
                    cnt_q  <= '0;
                    conv_q <= !conv_q;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
                GRD_POST: if (win_end) begin
                    st_q <= GRD_IDLE;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
                default: st_q <= GRD_IDLE;
            endcase
        end
    end

    assign conv_o = conv_q;
    assign busy_o = (st_q != GRD_IDLE);

    // R10
    conv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == GRD_IDLE) && !allow_i) |=> $stable(conv_q));

endmodule

// File: rtl/curadc_readout.sv
// Top of the current-ADC readout controller. It resynchronises the ready
// line, turns its falling edge into a frame request, arbitrates frames
// against the integrator-swap guard, and flags ready edges that arrive mid-frame.
// Assumes: sdata_i changes only in response to dclk_o falls.
module curadc_readout #(
    parameter int NCH       = 32,
    parameter int WMAX      = 20,
    parameter int WSHORT    = 16,
    parameter int DIV_HALF  = 4,
    parameter int GUARD_CYC = 1250
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      fmt20_i,
    input  logic                      conv_req_i,
    input  logic                      drdy_n_i,
    input  logic                      sdata_i,
    output logic                      dclk_o,
    output logic                      conv_o,
    output logic [WMAX-1:0]           word_o,
    output logic [$clog2(NCH)-1:0]    chan_o,
    output logic                      word_valid_o,
    output logic signed [WMAX:0]      word_signed_o,
    output logic                      overrun_o
);
    logic dv_s1, dv_s2, dv_s3, dv_fall;
    logic dv_pend_q, ovr_q;
    logic run, start, gbusy, rise, fall, dclk;

    assign dv_fall = dv_s3 && !dv_s2;
    assign start   = dv_pend_q && !run && !gbusy;

    // Two-flop resynchroniser plus edge-history flop for the ready line
    always_ff @(posedge clk) begin
        if (!rst_n) {dv_s1, dv_s2, dv_s3} <= 3'b111;
        else        {dv_s1, dv_s2, dv_s3} <= {drdy_n_i, dv_s1, dv_s2};
    end

    // Pending frame request and sticky overrun flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dv_pend_q <= 1'b0;
            ovr_q     <= 1'b0;
        end else begin
            if (start)               dv_pend_q <= 1'b0;
            else if (dv_fall && !run) dv_pend_q <= 1'b1;
            if (dv_fall && run)      ovr_q     <= 1'b1;
        end
    end

    curadc_rdo_sclk #(.DIV_HALF(DIV_HALF)) u_sclk (
        .clk(clk), .rst_n(rst_n), .run_i(run),
        .dclk_o(dclk), .rise_o(rise), .fall_o(fall)
    );

    curadc_rdo_frame #(.NCH(NCH), .WMAX(WMAX), .WSHORT(WSHORT)) u_frame (
        .clk(clk), .rst_n(rst_n), .start_i(start), .fmt20_i(fmt20_i),
        .sdata_i(sdata_i), .rise_i(rise), .fall_i(fall), .run_o(run),
        .word_o(word_o), .chan_o(chan_o), .valid_o(word_valid_o),
        .sval_o(word_signed_o)
    );

    curadc_rdo_guard #(.GUARD_CYC(GUARD_CYC)) u_guard (
        .clk(clk), .rst_n(rst_n), .req_i(conv_req_i),
        .allow_i(!run && !dv_pend_q), .conv_o(conv_o), .busy_o(gbusy)
    );

    assign dclk_o    = dclk;
    assign overrun_o = ovr_q;

    // R8
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_q |=> ovr_q);
    // R9
    guard_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gbusy |=> $stable(dclk));
    // R10
    frame_guard_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(run && gbusy));
    // R1
    start_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> $past(dv_pend_q));

endmodule

// File: tb/curadc_readout_tb.sv
module curadc_readout_tb;
    localparam int NCH   = 32;
    localparam int WMAX  = 20;
    localparam int DIVH  = 2;
    localparam int GUARD = 40;

    logic clk = 1'b0, rst_n = 1'b0;
    logic fmt20 = 1'b1, conv_req = 1'b0, drdy_n = 1'b1, sdata;
    logic dclk, conv, wvalid, ovr;
    logic [WMAX-1:0] word;
    logic [4:0] chan;
    logic signed [WMAX:0] wsig;

    always #4 clk = !clk;

    curadc_readout #(.NCH(NCH), .WMAX(WMAX), .WSHORT(16), .DIV_HALF(DIVH),
                     .GUARD_CYC(GUARD)) u_dut (
        .clk(clk), .rst_n(rst_n), .fmt20_i(fmt20), .conv_req_i(conv_req),
        .drdy_n_i(drdy_n), .sdata_i(sdata), .dclk_o(dclk), .conv_o(conv),
        .word_o(word), .chan_o(chan), .word_valid_o(wvalid),
        .word_signed_o(wsig), .overrun_o(ovr)
    );

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    // converter model state
    logic [19:0] raw [NCH];
    bit   bfmt = 1'b1;
    int   fall_cnt = 0, fall_base = 0, rise_cnt = 0;

    function automatic logic [19:0] exp_word(input int ch, input bit f);
        return f ? raw[ch] : (raw[ch] >> 4);
    endfunction

    function automatic logic model_bit(input int idx);
        int w;
        logic [19:0] v;
        w = bfmt ? 20 : 16;
        if (idx < 0 || idx >= NCH * w) return 1'b0;
        v = exp_word(NCH - 1 - idx / w, bfmt);
        return v[w - 1 - idx % w];
    endfunction

    always @(negedge dclk) fall_cnt <= fall_cnt + 1;
    always @(posedge dclk) rise_cnt <= rise_cnt + 1;
    always_comb sdata = model_bit(fall_cnt - fall_base);

    // receive log and timing monitors
    logic [19:0] rx_w [1024];
    logic [4:0]  rx_c [1024];
    longint      rx_s [1024];
    int rx_n = 0, cyc = 0, last_dclk = -100000, last_conv = -100000;
    int gap_bad = 0, hp_bad = 0, vwide = 0;
    bit conv_seen = 0;
    logic prev_dclk = 1'b0, prev_conv = 1'b0, prev_valid = 1'b0;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if (wvalid) begin
                rx_w[rx_n] <= word;
                rx_c[rx_n] <= chan;
                rx_s[rx_n] <= longint'(wsig);
                rx_n <= rx_n + 1;
                if (prev_valid) vwide <= vwide + 1;
            end
            if (dclk != prev_dclk) begin
                if ((cyc - last_dclk) != DIVH && (cyc - last_dclk) < GUARD) hp_bad <= hp_bad + 1;
                if (conv_seen && (cyc - last_conv) < GUARD) gap_bad <= gap_bad + 1;
                last_dclk <= cyc;
            end
            if (conv != prev_conv) begin
                if ((cyc - last_dclk) < GUARD) gap_bad <= gap_bad + 1;
                last_conv <= cyc;
                conv_seen <= 1'b1;
            end
        end
        prev_dclk  <= dclk;
        prev_conv  <= conv;
        prev_valid <= wvalid;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // launch one frame, optionally flipping format, injecting a ready pulse
    // or a swap request mid-frame, then check every word
    task automatic run_frame(input bit f, input bit flip, input bit ovr_pulse,
                             input bit conv_mid);
        int base_rx, base_rise, w;
        for (int i = 0; i < NCH; i++) raw[i] = 20'($urandom);
        raw[NCH-1] = 20'h00000;
        raw[0]     = 20'hFFFFF;
        raw[7]     = 20'h01000;
        raw[8]     = 20'h0100F;
        w = f ? 20 : 16;
        @(negedge clk);
        fmt20 = f;
        bfmt  = f;
        base_rx = rx_n;
        base_rise = rise_cnt;
        fall_base = fall_cnt;
        drdy_n = 1'b0;
        @(negedge dclk);
        drdy_n = 1'b1;
        @(negedge clk);
        if (flip) fmt20 = !f;
        if (conv_mid) begin
            conv_req = 1'b1;
            @(negedge clk);
            conv_req = 1'b0;
        end
        if (ovr_pulse) begin
            repeat (200) @(negedge clk);
            drdy_n = 1'b0;
            repeat (4) @(negedge clk);
            drdy_n = 1'b1;
        end
        while (rx_n < base_rx + NCH) @(negedge clk);
        if (conv_mid) chk(conv == 1'b0, "R10", "swap deferred during frame", conv, 0);
        repeat (GUARD + 4 * DIVH) @(negedge clk);
        chk(rise_cnt - base_rise == NCH * w, "R3/R1", "dclk rises in frame",
            rise_cnt - base_rise, NCH * w);
        chk(dclk == 1'b0, "R2", "dclk low after frame", dclk, 0);
        chk(rx_n == base_rx + NCH, "R6", "words per frame", rx_n - base_rx, NCH);
        for (int k = 0; k < NCH; k++) begin
            longint e, s;
            e = longint'(exp_word(NCH - 1 - k, f));
            s = e - (f ? 4096 : 256);
            chk(rx_c[base_rx + k] == 5'(NCH - 1 - k), "R4", "channel order",
                rx_c[base_rx + k], NCH - 1 - k);
            chk(longint'(rx_w[base_rx + k]) == e, "R5", "word value",
                rx_w[base_rx + k], e);
            chk(rx_s[base_rx + k] == s, "R7", "signed value", rx_s[base_rx + k], s);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        // R11 reset state
        chk(dclk == 0, "R11", "dclk at reset", dclk, 0);
        chk(conv == 0, "R11", "conv at reset", conv, 0);
        chk(wvalid == 0, "R11", "valid at reset", wvalid, 0);
        chk(ovr == 0, "R11", "overrun at reset", ovr, 0);
        rst_n = 1'b1;
        repeat (100) @(negedge clk);
        chk(rise_cnt == 0, "R1", "no clocking without ready edge", rise_cnt, 0);

        run_frame(1'b1, 1'b0, 1'b0, 1'b0);
        run_frame(1'b0, 1'b0, 1'b0, 1'b0);
        // R3 latched format: flip mid-frame both ways
        run_frame(1'b1, 1'b1, 1'b0, 1'b0);
        run_frame(1'b0, 1'b1, 1'b0, 1'b0);
        chk(ovr == 0, "R8", "no overrun after clean frames", ovr, 0);

        // R10 swap request inside a frame
        run_frame(1'b1, 1'b0, 1'b0, 1'b1);
        repeat (3 * GUARD) @(negedge clk);
        chk(conv == 1'b1, "R9", "swap applied after frame", conv, 1);

        // R10 ready edge right after a swap request, inside the guard window
        @(negedge clk);
        conv_req = 1'b1;
        @(negedge clk);
        conv_req = 1'b0;
        @(negedge clk);
        run_frame(1'b0, 1'b0, 1'b0, 1'b0);
        chk(conv == 1'b0, "R10", "swap before deferred frame", conv, 0);

        // R8 ready pulse during a frame
        run_frame(1'b1, 1'b0, 1'b1, 1'b0);
        chk(ovr == 1'b1, "R8", "overrun set", ovr, 1);
        run_frame(1'b0, 1'b0, 1'b0, 1'b0);
        chk(ovr == 1'b1, "R8", "overrun sticky", ovr, 1);

        for (int r = 0; r < 3; r++) run_frame(1'($urandom), 1'b0, 1'b0, 1'b0);

        chk(gap_bad == 0, "R9", "dclk edges inside guard windows", gap_bad, 0);
        chk(hp_bad == 0, "R2", "dclk half periods off", hp_bad, 0);
        chk(vwide == 0, "R6", "strobes wider than one cycle", vwide, 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule